// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes a byte between two ports, A and B, in either direction. Each port has a storage register with its own clock. The A register samples port A on every rising edge of the A clock. The B register samples port B on every rising edge of the B clock. Capture does not depend on the output controls, so either register can be loaded while both ports are released, and also while the other port is being driven.

An active-low output enable and a direction bit decide which port, if any, is driven. Each direction has a source select. It chooses either the live value on the opposite port or the contents of the opposite port's register. Each port is brought out as separate input, output and output-enable signals, so no tri-state nets are needed. A pad ring or a bus wrapper can merge them where the chip needs a true shared bus.

Top module: `reg_bus_xcvr`

## Requirements
- R1: After an active-low reset, both storage registers hold zero.
- R2: On every rising edge of clk_a_i, the A register loads a_i, whatever the values of oe_ni and dir_i.
- R3: On every rising edge of clk_b_i, the B register loads b_i, whatever the values of oe_ni and dir_i.
- R4: While oe_ni is 1, a_oe_o and b_oe_o are both 0.
- R5: While oe_ni is 0, dir_i = 0 gives a_oe_o = 1 and b_oe_o = 0, and dir_i = 1 gives b_oe_o = 1 and a_oe_o = 0.
- R6: While port A is driven and sel_b2a_i = 0, a_o follows b_i combinationally.
- R7: While port A is driven and sel_b2a_i = 1, a_o equals the B register contents.
- R8: While port B is driven and sel_a2b_i = 0, b_o follows a_i combinationally.
- R9: While port B is driven and sel_a2b_i = 1, b_o equals the A register contents.
- R10: a_oe_o and b_oe_o are never 1 at the same time.
- R11: When a port is driven and its own clock rises, its register loads that port's input value, which on a looped-back bus is the value being driven.
- R12: A port whose output enable is 0 presents all-zero output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Capture clock of the A register |
| clk_b_i | input | 1 | Capture clock of the B register |
| rst_ni | input | 1 | Asynchronous active-low reset of both registers |
| oe_ni | input | 1 | Active-low output enable for both ports |
| dir_i | input | 1 | 0 drives port A, 1 drives port B |
| sel_a2b_i | input | 1 | Source for port B: 0 live a_i, 1 stored A |
| sel_b2a_i | input | 1 | Source for port A: 0 live b_i, 1 stored B |
| a_i | input | W | Port A input data |
| a_o | output | W | Port A output data |
| a_oe_o | output | 1 | Port A output enable |
| b_i | input | W | Port B input data |
| b_o | output | W | Port B output data |
| b_oe_o | output | 1 | Port B output enable |

## Verification
Directed steps come first. Reading both registers just after reset proves they start cleared. A byte loaded during isolation and then read through the stored path proves capture is not gated by the output controls. After that, random control words are mixed with random data on the undriven port. The driven port's input is looped back from its own output, as it would be on a shared bus. Clock pulses on either port, or both together, are interleaved with these steps. Live and stored sources are told apart because the register contents and the opposite input normally differ. This also exposes a swapped select or a swapped direction decode. Capture while driven is separated from capture while idle by checking the stored value later, through the opposite port.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    XM_ISOLATE = 2'd0,
    XM_DRIVE_A = 2'd1,
    XM_DRIVE_B = 2'd2
  } xcvr_mode_e;

  function automatic xcvr_mode_e decode_mode(logic oe_n, logic dir);
    if (oe_n)     return XM_ISOLATE;
    else if (dir) return XM_DRIVE_B;
    else          return XM_DRIVE_A;
  endfunction
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_dir_dec.sv
module xcvr_dir_dec
  import xcvr_pkg::*;
(
  input  logic oe_ni,
  input  logic dir_i,
  output logic a_oe_o,
  output logic b_oe_o
);
  xcvr_mode_e mode;

  always_comb begin
    mode   = decode_mode(oe_ni, dir_i);
    a_oe_o = (mode == XM_DRIVE_A);
    b_oe_o = (mode == XM_DRIVE_B);
  end
endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux #(
  parameter int W = 8
) (
  input  logic         en_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] data_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign data_o[i] = en_i & (sel_i ? stored_i[i] : live_i[i]);
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         sel_a2b_i,
  input  logic         sel_b2a_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;

  // capture is never gated by output controls
  xcvr_cap_reg #(.W(W)) u_reg_a (
    .clk_i (clk_a_i),
    .rst_ni(rst_ni),
    .d_i   (a_i),
    .q_o   (a_q)
  );

  xcvr_cap_reg #(.W(W)) u_reg_b (
    .clk_i (clk_b_i),
    .rst_ni(rst_ni),
    .d_i   (b_i),
    .q_o   (b_q)
  );

  xcvr_dir_dec u_dec (
    .oe_ni (oe_ni),
    .dir_i (dir_i),
    .a_oe_o(a_oe_o),
    .b_oe_o(b_oe_o)
  );

  xcvr_out_mux #(.W(W)) u_mux_a (
    .en_i    (a_oe_o),
    .sel_i   (sel_b2a_i),
    .live_i  (b_i),
    .stored_i(b_q),
    .data_o  (a_o)
  );

  xcvr_out_mux #(.W(W)) u_mux_b (
    .en_i    (b_oe_o),
    .sel_i   (sel_a2b_i),
    .live_i  (a_i),
    .stored_i(a_q),
    .data_o  (b_o)
  );
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk_a_i,
  input logic         clk_b_i,
  input logic         rst_ni,
  input logic         oe_ni,
  input logic         dir_i,
  input logic         sel_a2b_i,
  input logic         sel_b2a_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_oe_o,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);
  a_r2_capture_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    1'b1 |=> a_q == $past(a_i));

  a_r3_capture_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    1'b1 |=> b_q == $past(b_i));

  a_r4_isolate: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    oe_ni |-> !a_oe_o && !b_oe_o);

  a_r5_dir: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !oe_ni |-> (a_oe_o == !dir_i) && (b_oe_o == dir_i));

  a_r7_stored_b2a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    a_oe_o && sel_b2a_i |-> a_o == b_q);

  a_r9_stored_a2b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    b_oe_o && sel_a2b_i |-> b_o == a_q);

  a_r10_one_driver: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  a_r12_idle_zero: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !a_oe_o |-> a_o == '0);
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.W(W)) u_chk (
  .clk_a_i  (clk_a_i),
  .clk_b_i  (clk_b_i),
  .rst_ni   (rst_ni),
  .oe_ni    (oe_ni),
  .dir_i    (dir_i),
  .sel_a2b_i(sel_a2b_i),
  .sel_b2a_i(sel_b2a_i),
  .a_i      (a_i),
  .a_o      (a_o),
  .a_oe_o   (a_oe_o),
  .b_i      (b_i),
  .b_o      (b_o),
  .b_oe_o   (b_oe_o),
  .a_q      (a_q),
  .b_q      (b_q)
);

// File: tb/reg_bus_xcvr_bench.sv
module reg_bus_xcvr_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_a2b = 1'b0, sel_b2a = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0, fails = 0;
  logic [W-1:0] m_aq = '0, m_bq = '0;

  always #2.5 clk = ~clk;

  reg_bus_xcvr #(.W(W)) u_reg_bus_xcvr (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .oe_ni(oe_n), .dir_i(dir), .sel_a2b_i(sel_a2b), .sel_b2a_i(sel_b2a),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  function automatic logic f_a_oe(logic on, logic d);
    return !on && !d;
  endfunction
  function automatic logic f_b_oe(logic on, logic d);
    return !on && d;
  endfunction
  function automatic logic [W-1:0] f_out(logic en, logic sel, logic [W-1:0] live, logic [W-1:0] st);
    if (!en) return '0;
    return sel ? st : live;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic ea, eb;
    ea = f_a_oe(oe_n, dir);
    eb = f_b_oe(oe_n, dir);
    check({tag, " R5/R4 a_oe"}, {7'd0, a_oe}, {7'd0, ea});
    check({tag, " R5/R4 b_oe"}, {7'd0, b_oe}, {7'd0, eb});
    check({tag, " R6/R7/R12 a_o"}, a_out, f_out(ea, sel_b2a, b_in, m_bq));
    check({tag, " R8/R9/R12 b_o"}, b_out, f_out(eb, sel_a2b, a_in, m_aq));
    check({tag, " R10 one driver"}, {7'd0, a_oe & b_oe}, 8'd0);
  endtask

  task automatic pulse(logic pa, logic pb);
    @(negedge clk);
    clk_a = pa; clk_b = pb;
    @(negedge clk);
    clk_a = 1'b0; clk_b = 1'b0;
    if (pa) m_aq = a_in;
    if (pb) m_bq = b_in;
  endtask

  task automatic set_ctl(logic on, logic d, logic sab, logic sba);
    @(negedge clk);
    oe_n = on; dir = d; sel_a2b = sab; sel_b2a = sba;
    #1;
  endtask

  initial begin
    #(5.0 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: stored paths show cleared registers
    a_in = 8'hA5; b_in = 8'h3C;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    check("R1 stored A after reset", b_out, 8'h00);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    b_in = 8'h3C; #1;
    check("R1 stored B after reset", a_out, 8'h00);

    // R2 R3: capture during isolation
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    check_all("R4 isolate");
    a_in = 8'h5A; b_in = 8'hC3;
    pulse(1'b1, 1'b1);
    a_in = 8'h11; b_in = 8'h22;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    check("R2 A captured in isolation", b_out, 8'h5A);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 B captured in isolation", a_out, 8'hC3);

    // R11: capture on driven port A (looped back), then read through B
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    b_in = 8'h77; #1;
    a_in = a_out;
    pulse(1'b1, 1'b0);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    a_in = 8'h00; #1;
    check("R11 capture while driven", b_out, 8'h77);

    // live paths R6 R8
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    b_in = 8'h9E; #1;
    check("R6 live b to a", a_out, 8'h9E);
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    a_in = 8'h4D; #1;
    check("R8 live a to b", b_out, 8'h4D);
    check("R12 a idle zero", a_out, 8'h00);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      logic on, d, sab, sba, pa, pb;
      {on, d, sab, sba, pa, pb} = 6'($urandom);
      set_ctl(on, d, sab, sba);
      if (f_a_oe(on, d)) begin
        b_in = W'($urandom); #1; a_in = a_out;
      end else if (f_b_oe(on, d)) begin
        a_in = W'($urandom); #1; b_in = b_out;
      end else begin
        a_in = W'($urandom); b_in = W'($urandom);
      end
      #1;
      check_all("R2/R3/R11 random");
      pulse(pa, pb);
      #1;
      check_all("R2/R3 after pulse");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule